// File: doc/BRIEF.md
# Window-Threshold Alarm Monitor

The block watches a stream of conversion results, such as supply voltages, the reference, external inputs and die temperature. Each result carries a channel index and is compared against that channel's own lower and upper limit. A result outside the window is an alarm event. The event sets that channel's sticky status bit, sets a single global alarm flag and, unless the channel is masked, drives an active-high alarm pin.

Software uses a simple register port to program limits, the mask and the mode, and to read status. Reading the per-channel status word clears it, and reading the general status word clears the global flag. One configuration bit selects the mode. In latched mode the global flag and the pin hold until general status is read. In transparent mode they follow the most recent result of every channel. The per-channel status bits stay sticky in both modes.

Register map (word addresses): 0 = configuration (bit 0: 1 selects transparent mode); 1 = pin mask (bit i = 1 masks channel i); 2 = channel status (bit i, clears on read); 3 = general status (bit 0 = global flag); 4+2·i = lower limit of channel i; 5+2·i = upper limit of channel i.

Top module: `win_alarm_mon`

## Requirements
- R1: A result for channel i raises an event only if the value is strictly below the lower limit or strictly above the upper limit. On an event, bit i of the status word (address 2) is 1 from the next cycle. A value equal to either limit counts as in range.
- R2: Status bits stay set until a read of address 2. That read returns the word as it was before the read and clears it, in either mode.
- R3: After a status bit is cleared, another out-of-range result for the same channel sets it again.
- R4: Every event, masked or not, sets the global flag, which reads as bit 0 of address 3.
- R5: When mask bit i (address 1) is 1, events on channel i do not drive the alarm pin but still set status bit i.
- R6: With configuration bit 0 at 0 (latched mode), the global flag and the pin stay at 1 after the condition goes away, until a read of address 3 clears them.
- R7: With configuration bit 0 at 1 (transparent mode), the global flag is the OR over all channels of "latest result was out of range". The pin is the same OR restricted to unmasked channels. Both take effect one cycle later, and a read has no effect on them.
- R8: If an event and a clearing read of the same register arrive in the same cycle, the event wins and the bit or flag ends up at 1.
- R9: The alarm pin is active-high and comes from a register. It rises in the cycle after the triggering result and is never 1 while the global flag is 0.
- R10: After reset the pin is 0, all status is 0, the mode is latched, the mask is 0, lower limits are 0 and upper limits are all ones. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears on read where the register defines it) |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid one cycle after reg_rd |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_ch | input | CH_W | Channel index of the result |
| res_value | input | DATA_W | Conversion result |
| alarm_o | output | 1 | Active-high registered alarm pin |

## Verification
The bench builds the block with its defaults: eight channels, 12-bit results and a 16-bit register port. With these values every address from 0 to 19 is decoded, so every limit register is written and read back. Results are often placed one count either side of a limit, so the equality boundary comes up many times in the random phase. The random phase also switches mode in the middle of activity, which lets both the latched and the transparent behaviour meet a mask that has just changed, as well as a read that lands in the same cycle as an event.

// File: rtl/win_alarm_pkg.sv
package win_alarm_pkg;
   localparam int ADDR_CFG  = 0;
   localparam int ADDR_MASK = 1;
   localparam int ADDR_STAT = 2;
   localparam int ADDR_GEN  = 3;
   localparam int ADDR_LIM0 = 4;

   function automatic int addr_bits(input int nch);
      return $clog2(ADDR_LIM0 + 2 * nch);
   endfunction

   function automatic int ch_bits(input int nch);
      return (nch > 1) ? $clog2(nch) : 1;
   endfunction
endpackage

// File: rtl/wam_limits.sv
module wam_limits #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 12,
   parameter int ADDR_W = 5,
   parameter int REG_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [REG_W-1:0]         wdata,
   output logic [NUM_CH*DATA_W-1:0] lo_flat,
   output logic [NUM_CH*DATA_W-1:0] hi_flat
);
   import win_alarm_pkg::*;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(ADDR_LIM0 + 2 * i);
      localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(ADDR_LIM0 + 2 * i + 1);
      logic [DATA_W-1:0] lo_q, hi_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '1;
         end else if (wr) begin
            if (addr == LO_ADDR) lo_q <= wdata[DATA_W-1:0];
            if (addr == HI_ADDR) hi_q <= wdata[DATA_W-1:0];
         end
      end

      assign lo_flat[i*DATA_W +: DATA_W] = lo_q;
      assign hi_flat[i*DATA_W +: DATA_W] = hi_q;
   end
endmodule

// File: rtl/wam_compare.sv
module wam_compare #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 12,
   parameter int CH_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     res_valid,
   input  logic [CH_W-1:0]          res_ch,
   input  logic [DATA_W-1:0]        res_value,
   input  logic [NUM_CH*DATA_W-1:0] lo_flat,
   input  logic [NUM_CH*DATA_W-1:0] hi_flat,
   output logic [NUM_CH-1:0]        set_vec,
   output logic [NUM_CH-1:0]        cond_nxt,
   output logic                     oor_hit
);
   logic [NUM_CH-1:0] cond_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_win
      logic hit, below, above;
      assign hit   = res_valid && (res_ch == CH_W'(i));
      assign below = res_value < lo_flat[i*DATA_W +: DATA_W];
      assign above = res_value > hi_flat[i*DATA_W +: DATA_W];
      assign set_vec[i]  = hit && (below || above);
      assign cond_nxt[i] = hit ? (below || above) : cond_q[i];
   end

   assign oor_hit = |set_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= '0;
      else        cond_q <= cond_nxt;
   end
endmodule

// File: rtl/wam_alarm.sv
module wam_alarm #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_vec,
   input  logic [NUM_CH-1:0] cond_nxt,
   input  logic [NUM_CH-1:0] mask,
   input  logic              latch_dis,
   input  logic              stat_clr,
   input  logic              gen_clr,
   output logic [NUM_CH-1:0] stat_q,
   output logic              glob_q,
   output logic              pin_q
);
   logic ev_any, ev_pin, lvl_any, lvl_pin;

   assign ev_any  = |set_vec;
   assign ev_pin  = |(set_vec & ~mask);
   assign lvl_any = |cond_nxt;
   assign lvl_pin = |(cond_nxt & ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         glob_q <= 1'b0;
         pin_q  <= 1'b0;
      end else begin
         stat_q <= (stat_clr ? '0 : stat_q) | set_vec;
         if (latch_dis) begin
            glob_q <= lvl_any;
            pin_q  <= lvl_pin;
         end else begin
            glob_q <= (glob_q && !gen_clr) || ev_any;
            pin_q  <= (pin_q  && !gen_clr) || ev_pin;
         end
      end
   end
endmodule

// File: rtl/win_alarm_mon.sv
module win_alarm_mon #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 12,
   parameter int REG_W  = 16,
   parameter int ADDR_W = win_alarm_pkg::addr_bits(NUM_CH),
   parameter int CH_W   = win_alarm_pkg::ch_bits(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              res_valid,
   input  logic [CH_W-1:0]   res_ch,
   input  logic [DATA_W-1:0] res_value,
   output logic              alarm_o
);
   import win_alarm_pkg::*;

   if (REG_W < DATA_W || REG_W < NUM_CH) begin : g_bad_regw
      $error("REG_W must hold a limit and a full mask");
   end
   if (ADDR_W < addr_bits(NUM_CH)) begin : g_bad_addrw
      $error("ADDR_W too small for the register map");
   end
   if (CH_W < ch_bits(NUM_CH)) begin : g_bad_chw
      $error("CH_W too small for NUM_CH");
   end

   logic                     latch_dis_q;
   logic [NUM_CH-1:0]        mask_q;
   logic [NUM_CH*DATA_W-1:0] lo_flat, hi_flat;
   logic [NUM_CH-1:0]        set_vec, cond_nxt, stat_q;
   logic                     oor_hit, glob_q, stat_clr, gen_clr;
   logic [REG_W-1:0]         rd_d;

   assign stat_clr = reg_rd && (reg_addr == ADDR_W'(ADDR_STAT));
   assign gen_clr  = reg_rd && (reg_addr == ADDR_W'(ADDR_GEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_dis_q <= 1'b0;
         mask_q      <= '0;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(ADDR_CFG))  latch_dis_q <= reg_wdata[0];
         if (reg_addr == ADDR_W'(ADDR_MASK)) mask_q      <= reg_wdata[NUM_CH-1:0];
      end
   end

   wam_limits #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_lim (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .lo_flat(lo_flat), .hi_flat(hi_flat)
   );

   wam_compare #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
      .res_value(res_value), .lo_flat(lo_flat), .hi_flat(hi_flat),
      .set_vec(set_vec), .cond_nxt(cond_nxt), .oor_hit(oor_hit)
   );

   wam_alarm #(.NUM_CH(NUM_CH)) u_alm (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .cond_nxt(cond_nxt),
      .mask(mask_q), .latch_dis(latch_dis_q), .stat_clr(stat_clr), .gen_clr(gen_clr),
      .stat_q(stat_q), .glob_q(glob_q), .pin_q(alarm_o)
   );

   always_comb begin
      rd_d = '0;
      if (reg_addr == ADDR_W'(ADDR_CFG))  rd_d[0] = latch_dis_q;
      if (reg_addr == ADDR_W'(ADDR_MASK)) rd_d[NUM_CH-1:0] = mask_q;
      if (reg_addr == ADDR_W'(ADDR_STAT)) rd_d[NUM_CH-1:0] = stat_q;
      if (reg_addr == ADDR_W'(ADDR_GEN))  rd_d[0] = glob_q;
      for (int i = 0; i < NUM_CH; i++) begin
         if (reg_addr == ADDR_W'(ADDR_LIM0 + 2 * i))
            rd_d[DATA_W-1:0] = lo_flat[i*DATA_W +: DATA_W];
         if (reg_addr == ADDR_W'(ADDR_LIM0 + 2 * i + 1))
            rd_d[DATA_W-1:0] = hi_flat[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_d;
   end
endmodule

// File: rtl/wam_chk.sv
module wam_chk #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              res_valid,
   input logic [CH_W-1:0]   res_ch,
   input logic              oor_hit,
   input logic [NUM_CH-1:0] stat_q,
   input logic              stat_clr,
   input logic              gen_clr,
   input logic              glob_q,
   input logic              latch_dis,
   input logic              alarm_o
);
   // R1
   oor_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && oor_hit) |=> stat_q[$past(res_ch)]);

   // R2
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~stat_q & $past(stat_q)) != '0) |-> $past(stat_clr));

   // R6
   glob_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(glob_q) && !$past(latch_dis)) |-> $past(gen_clr));

   // R6
   pin_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(alarm_o) && !$past(latch_dis)) |-> $past(gen_clr));

   // R9
   pin_under_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o |-> glob_q);
endmodule

bind win_alarm_mon wam_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_wam_chk (
   .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
   .oor_hit(oor_hit), .stat_q(stat_q), .stat_clr(stat_clr), .gen_clr(gen_clr),
   .glob_q(glob_q), .latch_dis(latch_dis_q), .alarm_o(alarm_o)
);

// File: tb/win_alarm_mon_tb_top.sv
module win_alarm_mon_tb_top;
   localparam int NCH = 8;
   localparam int DW  = 12;
   localparam int RW  = 16;
   localparam int AW  = 5;
   localparam int CW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [RW-1:0] reg_wdata = '0;
   logic [RW-1:0] reg_rdata;
   logic          res_valid = 1'b0;
   logic [CW-1:0] res_ch = '0;
   logic [DW-1:0] res_value = '0;
   logic          alarm_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference state kept from the requirements
   logic [DW-1:0]  lo_m [NCH];
   logic [DW-1:0]  hi_m [NCH];
   logic [NCH-1:0] mask_m, stat_m, cond_m;
   logic           lat_m, glob_m, pin_m;

   always #4 clk = ~clk;

   win_alarm_mon #(.NUM_CH(NCH), .DATA_W(DW), .REG_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_valid(res_valid),
      .res_ch(res_ch), .res_value(res_value), .alarm_o(alarm_o)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [RW-1:0] exp_rd(input int a);
      logic [RW-1:0] v = '0;
      if (a == 0) v[0] = lat_m;
      else if (a == 1) v[NCH-1:0] = mask_m;
      else if (a == 2) v[NCH-1:0] = stat_m;
      else if (a == 3) v[0] = glob_m;
      else if (((a - 4) >> 1) < NCH) v[DW-1:0] = ((a - 4) & 1) ? hi_m[(a - 4) >> 1] : lo_m[(a - 4) >> 1];
      return v;
   endfunction

   // one clock: drive at negedge, update the reference, check at the next negedge
   task automatic step(input bit wr, input bit rd, input int a, input int wd,
                       input bit v, input int ch, input int val, input string tag);
      logic [RW-1:0]  er;
      logic [NCH-1:0] setv;
      bit out;
      reg_wr = wr; reg_rd = rd; reg_addr = AW'(a); reg_wdata = RW'(wd);
      res_valid = v; res_ch = CW'(ch); res_value = DW'(val);
      er = exp_rd(a);
      setv = '0;
      if (v) begin
         out = (DW'(val) < lo_m[ch]) || (DW'(val) > hi_m[ch]);
         cond_m[ch] = out;
         setv[ch] = out;
      end
      stat_m = ((rd && a == 2) ? '0 : stat_m) | setv;
      if (lat_m) begin
         glob_m = |cond_m;
         pin_m  = |(cond_m & ~mask_m);
      end else begin
         glob_m = (glob_m && !(rd && a == 3)) || (|setv);
         pin_m  = (pin_m && !(rd && a == 3)) || (|(setv & ~mask_m));
      end
      if (wr) begin
         if (a == 0) lat_m = wd[0];
         else if (a == 1) mask_m = NCH'(wd);
         else if (a >= 4 && ((a - 4) >> 1) < NCH) begin
            if ((a - 4) & 1) hi_m[(a - 4) >> 1] = DW'(wd);
            else             lo_m[(a - 4) >> 1] = DW'(wd);
         end
      end
      @(posedge clk);
      @(negedge clk);
      reg_wr = 0; reg_rd = 0; res_valid = 0;
      chk(32'(alarm_o), 32'(pin_m), "R9 pin");
      if (rd) chk(32'(reg_rdata), 32'(er), tag);
   endtask

   task automatic res(input int ch, input int val);
      step(0, 0, 0, 0, 1, ch, val, "R1");
   endtask
   task automatic rd(input int a, input string tag);
      step(0, 1, a, 0, 0, 0, 0, tag);
   endtask
   task automatic wr(input int a, input int d);
      step(1, 0, a, d, 0, 0, 0, "R10");
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NCH; i++) begin lo_m[i] = '0; hi_m[i] = '1; end
      mask_m = '0; stat_m = '0; cond_m = '0; lat_m = 0; glob_m = 0; pin_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk(32'(alarm_o), 0, "R10 pin after reset");
      rd(4, "R10 lower limit reset");
      rd(5, "R10 upper limit reset");
      rd(2, "R10 status reset");
      rd(0, "R10 mode reset");

      // R1 strict window
      wr(8, 100); wr(9, 200);
      res(2, 100); rd(2, "R1 equal lower in range");
      res(2, 200); rd(2, "R1 equal upper in range");
      res(2, 99);  chk(32'(alarm_o), 1, "R1 pin below lower");
      rd(2, "R1 below lower sets bit");
      rd(3, "R6 clear global");

      // R3 reassert after clear
      res(2, 201); rd(2, "R3 first read"); rd(2, "R3 second read empty");
      chk(32'(reg_rdata), 0, "R3 cleared");
      res(2, 201); rd(2, "R3 set again");
      chk(32'(reg_rdata), 32'h4, "R3 bit back");
      rd(3, "R6 clear global");

      // R5 mask gates pin only, R4 global still set
      wr(1, 32'h4);
      res(2, 50); chk(32'(alarm_o), 0, "R5 masked pin low");
      rd(2, "R5 status still set"); chk(32'(reg_rdata), 32'h4, "R5 bit");
      rd(3, "R4 global from masked event"); chk(32'(reg_rdata), 1, "R4 global");
      wr(1, 0);

      // R8 event and clearing read in the same cycle
      wr(10, 10);
      step(0, 1, 2, 0, 1, 3, 5, "R8 read sees old");
      rd(2, "R8 event wins"); chk(32'(reg_rdata), 32'h8, "R8 bit");
      step(0, 1, 3, 0, 1, 3, 5, "R8 gen read");
      rd(3, "R8 global survives"); chk(32'(reg_rdata), 1, "R8 global");

      // R6 latched hold
      res(2, 50); res(2, 150); res(3, 20);
      chk(32'(alarm_o), 1, "R6 pin holds");
      rd(3, "R6 global holds"); chk(32'(reg_rdata), 1, "R6 global");
      chk(32'(alarm_o), 0, "R6 pin cleared by read");

      // R7 transparent
      wr(0, 1);
      res(2, 50); chk(32'(alarm_o), 1, "R7 pin follows");
      res(2, 150); chk(32'(alarm_o), 0, "R7 pin drops");
      rd(2, "R7 status still sticky");
      wr(0, 0);

      // random phase
      for (int it = 0; it < 600; it++) begin
         int op = $urandom % 16;
         int ch = $urandom % NCH;
         int val;
         case ($urandom % 3)
            0: val = int'(lo_m[ch]) + int'($urandom % 3) - 1;
            1: val = int'(hi_m[ch]) + int'($urandom % 3) - 1;
            default: val = $urandom % 4096;
         endcase
         val = val & 12'hFFF;
         if (op < 7)        res(ch, val);
         else if (op < 9)   rd(2, "R2 random status");
         else if (op == 9)  rd(3, lat_m ? "R7 random global" : "R6 random global");
         else if (op == 10) step(0, 1, 2, 0, 1, ch, val, "R8 random");
         else if (op == 11) wr(1, $urandom % 256);
         else if (op == 12) begin if ($urandom % 4 == 0) wr(0, lat_m ? 0 : 1); else res(ch, val); end
         else if (op == 13) begin
            int l = $urandom % 2048;
            wr(4 + 2 * ch, l); wr(5 + 2 * ch, l + ($urandom % 2048));
         end
         else rd(4 + ($urandom % (2 * NCH)), "R10 random limit");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule